// File: doc/BRIEF.md
# Transmit Frame Padder and FCS Generator

This block sits in front of the transmit line and turns a raw outgoing frame into a finished one. The frame arrives as a ready/valid byte stream with a last flag. A per-frame no-CRC sideband is sampled on the first byte of each frame. In the normal mode the block forwards the payload and then adds two things. If the frame holds fewer than 60 bytes, it appends zero bytes until the frame is 60 bytes long. It then appends the four-byte Ethernet frame check sequence, which covers the payload and any padding. When the no-CRC sideband is set for a frame, that frame passes through untouched.

Payload bytes flow through with no added latency: while payload is moving, the output valid follows the input valid and the input ready follows the output ready. During the padding and check-sequence tail the block produces the bytes itself and holds the input stream off. A stall on the output freezes the CRC, the padding count and the tail position, so no byte is lost or repeated.

Top module: `tx_pad_fcs`

## Requirements
- R1: The check value uses the bit-reflected polynomial 0xEDB88320. The register starts at all ones and is shifted once per bit, least-significant bit of each byte first. The transmitted check value is the bitwise inverse of the final register. Running the same register over a whole finished frame, check bytes included, therefore leaves the residue 0xDEBB20E3.
- R2: The four check bytes follow the last payload or padding byte directly. They are emitted least-significant byte first, and the CRC register is not advanced while they are sent.
- R3: With CRC insertion enabled, a frame of N < 60 bytes is followed by 60 − N bytes of value 0x00. The padding is included in the check value, so the finished frame is 64 bytes.
- R4: With CRC insertion enabled, a frame of 60 or more bytes gets no padding. Its finished length is N + 4.
- R5: The no-CRC sideband is sampled only with the first byte of a frame. When it is 1, the output frame equals the input frame byte for byte, with no padding and no check bytes. Its value on later bytes of the frame has no effect.
- R6: The output last flag is set only on the final check byte, or on the final payload byte of a no-CRC frame.
- R7: During the padding and check tail, input ready is 0. While the output is stalled in the tail, output valid stays 1 and the output byte stays unchanged.
- R8: Frames of up to 2047 bytes are handled correctly.
- R9: After reset the block is waiting for the first byte of a new frame. With input valid low, output valid is 0, and input ready equals output ready.
- R10: A payload byte appears on the output in the same cycle it is offered, with output data equal to input data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte valid |
| inLast | input | 1 | Final payload byte of the frame |
| inNoCrc | input | 1 | Skip padding and check sequence (sampled on first byte) |
| inReady | output | 1 | Block accepts the offered byte |
| outData | output | 8 | Finished-frame byte |
| outValid | output | 1 | Output byte valid |
| outLast | output | 1 | Final byte of the finished frame |
| outReady | input | 1 | Downstream accepts the output byte |

## Verification
Payload bytes are due combinationally in the cycle they are offered. Padding starts in the cycle after the last payload handshake, and each padding or check byte advances only on an output handshake. The bench drives inputs just after the falling edge and samples every port 1.5 ns later, before the next rising edge. A handshake seen there is exactly the transfer that edge commits. Finished frames are compared byte by byte against a bench model of padding and CRC, and the residue is recomputed over the received frame. A stalled tail byte is compared with the same byte one cycle later.

// File: rtl/tx_pad_fcs_pkg.sv
package tx_pad_fcs_pkg;

  localparam int BYTE_W    = 8;
  localparam int CRC_W     = 32;
  localparam int FCS_BYTES = CRC_W / BYTE_W;
  localparam int IDX_W     = $clog2(FCS_BYTES);
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } txPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             crcClear;
    logic             crcUpdate;
    logic             selPad;
    logic             selFcs;
    logic [IDX_W-1:0] fcsIdx;
  } dpStrobes_t;

  // one byte of reflected CRC, LSB first, one shift per bit
  function automatic logic [CRC_W-1:0] crcStepByte(input logic [CRC_W-1:0] crcIn,
                                                   input logic [BYTE_W-1:0] dataIn);
    logic [CRC_W-1:0] acc;
    acc = crcIn ^ {{(CRC_W-BYTE_W){1'b0}}, dataIn};
    for (int b = 0; b < BYTE_W; b++) begin
      acc = acc[0] ? ((acc >> 1) ^ CRC_POLY) : (acc >> 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/tx_pad_fcs_ctrl.sv
module tx_pad_fcs_ctrl
  import tx_pad_fcs_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 2047
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       inNoCrc,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       outLast,
  output dpStrobes_t strb
);

  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);

  txPhase_e         phase;
  logic             firstByte;
  logic             noCrcHeld;
  logic [CNT_W-1:0] byteCnt;
  logic [IDX_W-1:0] fcsIdx;

  logic             noCrcEff;
  logic [CNT_W-1:0] cntInc;
  logic [CNT_W-1:0] cntAfter;
  logic             xfer;

  assign noCrcEff = firstByte ? inNoCrc : noCrcHeld;
  assign cntInc   = byteCnt + CNT_W'(1);
  assign cntAfter = firstByte ? CNT_W'(1)
                  : ((byteCnt == CNT_W'(MAX_LEN)) ? byteCnt : cntInc);

  always_comb begin
    inReady        = 1'b0;
    outValid       = 1'b0;
    outLast        = 1'b0;
    xfer           = 1'b0;
    strb           = '0;
    strb.fcsIdx    = fcsIdx;
    unique case (phase)
      ST_DATA: begin
        inReady        = outReady;
        outValid       = inValid;
        outLast        = inLast && noCrcEff;
        xfer           = inValid && outReady;
        strb.crcUpdate = xfer && !noCrcEff;
      end
      ST_PAD: begin
        outValid       = 1'b1;
        strb.selPad    = 1'b1;
        xfer           = outReady;
        strb.crcUpdate = xfer;
      end
      ST_FCS: begin
        outValid       = 1'b1;
        strb.selFcs    = 1'b1;
        outLast        = (fcsIdx == LAST_IDX);
        xfer           = outReady;
        strb.crcClear  = xfer && (fcsIdx == LAST_IDX);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= ST_DATA;
      firstByte <= 1'b1;
      noCrcHeld <= 1'b0;
      byteCnt   <= '0;
      fcsIdx    <= '0;
    end else begin
      unique case (phase)
        ST_DATA: if (xfer) begin
          if (firstByte) noCrcHeld <= inNoCrc;
          byteCnt   <= cntAfter;
          firstByte <= inLast;
          fcsIdx    <= '0;
          if (inLast && !noCrcEff) begin
            phase <= (cntAfter < CNT_W'(MIN_LEN)) ? ST_PAD : ST_FCS;
          end
        end
        ST_PAD: if (xfer) begin
          byteCnt <= cntInc;
          if (cntInc == CNT_W'(MIN_LEN)) phase <= ST_FCS;
        end
        ST_FCS: if (xfer) begin
          fcsIdx <= fcsIdx + IDX_W'(1);
          if (fcsIdx == LAST_IDX) begin
            phase     <= ST_DATA;
            firstByte <= 1'b1;
          end
        end
        default: phase <= ST_DATA;
      endcase
    end
  end

  // R3: padding never runs past the minimum length
  p_pad_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_PAD) |-> (byteCnt < CNT_W'(MIN_LEN)));

  // R4: check bytes start only once the frame has reached the minimum length
  p_fcs_min_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_FCS) |-> (byteCnt >= CNT_W'(MIN_LEN)));

  // R5: a no-CRC frame never enters the tail
  p_tail_crc_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase != ST_DATA) |-> !noCrcHeld);

  // R6: after the final check byte the block waits for a new frame
  p_tail_return_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_FCS && outReady && fcsIdx == LAST_IDX) |=> (phase == ST_DATA && firstByte));

endmodule

// File: rtl/tx_pad_fcs_datapath.sv
module tx_pad_fcs_datapath
  import tx_pad_fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [BYTE_W-1:0] inData,
  output logic [BYTE_W-1:0] outData
);

  logic [CRC_W-1:0]  crcReg;
  logic [BYTE_W-1:0] fcsLane [FCS_BYTES];

  for (genvar g = 0; g < FCS_BYTES; g++) begin : g_lane
    assign fcsLane[g] = ~crcReg[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (strb.selFcs)      outData = fcsLane[strb.fcsIdx];
    else if (strb.selPad) outData = '0;
    else                  outData = inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.crcClear) crcReg <= '1;
    else if (strb.crcUpdate)    crcReg <= crcStepByte(crcReg, outData);
  end

  // R2: the register is frozen while its own check bytes go out
  p_no_update_in_fcs_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.crcUpdate |-> !strb.selFcs);

  // R3: zero fill and check output are never selected together
  p_sel_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.selPad && strb.selFcs));

endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
  import tx_pad_fcs_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 2047
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       inNoCrc,
  output logic       inReady,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       outLast,
  input  logic       outReady
);

  dpStrobes_t strb;

  tx_pad_fcs_ctrl #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .inNoCrc  (inNoCrc),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .strb     (strb)
  );

  tx_pad_fcs_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (inData),
    .outData (outData)
  );

  // R7: a stalled tail byte is held until taken
  p_tail_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.selPad || strb.selFcs) && !outReady) |=> (outValid && $stable(outData)));

  // R7: input is held off during the tail
  p_tail_blocks_input_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selPad || strb.selFcs) |-> !inReady);

endmodule

// File: tb/tx_pad_fcs_tb.sv
`timescale 1ns/1ps
module tx_pad_fcs_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] inData;
  logic       inValid;
  logic       inLast;
  logic       inNoCrc;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid;
  logic       outLast;
  logic       outReady;

  int totalChecks = 0;
  int failChecks  = 0;

  always #2 clk = ~clk;

  tx_pad_fcs dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inValid  (inValid),
    .inLast   (inLast),
    .inNoCrc  (inNoCrc),
    .inReady  (inReady),
    .outData  (outData),
    .outValid (outValid),
    .outLast  (outLast),
    .outReady (outReady)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    totalChecks++;
    if (!ok) begin
      failChecks++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic void buildExp(input logic [7:0] pay[$], input bit nc, ref logic [7:0] e[$]);
    logic [31:0] c;
    e = pay;
    if (nc) return;
    while (e.size() < 60) e.push_back(8'h00);
    c = 32'hFFFFFFFF;
    foreach (e[k]) c = refCrc(c, e[k]);
    c = ~c;
    for (int k = 0; k < 4; k++) e.push_back(c[k*8 +: 8]);
  endfunction

  task automatic runFrame(input int len, input bit nc, input bit lateFlip, input int stallPct);
    logic [7:0] pay[$];
    logic [7:0] exp[$];
    logic [7:0] got[$];
    logic [31:0] res;
    int  idx = 0;
    bit  offered = 0;
    bit  done = 0;
    bit  tailStall = 0;
    logic [7:0] heldByte = '0;
    string tag;
    for (int k = 0; k < len; k++) pay.push_back(8'($urandom));
    buildExp(pay, nc, exp);
    tag = nc ? "R5" : ((len < 60) ? "R3" : "R4");
    while (!done) begin
      @(negedge clk);
      if (idx < len) begin
        if (!offered) offered = (($urandom % 100) < 80);
        inValid = offered;
        inData  = pay[idx];
        inLast  = (idx == len - 1);
        inNoCrc = (idx == 0) ? nc : (lateFlip ? ~nc : nc);
      end else begin
        inValid = 1'b0;
        inLast  = 1'b0;
      end
      outReady = (($urandom % 100) >= stallPct);
      #1.5;
      if (tailStall)
        check(outValid && outData == heldByte, "R7 stalled tail byte", outData, heldByte);
      tailStall = (idx >= len) && outValid && !outReady;
      heldByte  = outData;
      if (idx >= len && !nc)
        check(!inReady, "R7 input held off in tail", inReady, 0);
      if (inValid && inReady)
        check(outValid && outData == inData, "R10 pass-through", outData, inData);
      if (outValid && outReady) begin
        got.push_back(outData);
        if (outLast) done = 1;
      end
      if (inValid && inReady) begin
        idx++;
        offered = 0;
      end
    end
    // R6: last flag position equals the finished length
    check(got.size() == exp.size(), {tag, " R6 finished length"}, got.size(), exp.size());
    for (int k = 0; k < exp.size() && k < got.size(); k++) begin
      if (k >= exp.size() - 4 && !nc)
        check(got[k] == exp[k], "R2 check byte", got[k], exp[k]);
      else
        check(got[k] == exp[k], {tag, " frame byte"}, got[k], exp[k]);
    end
    if (!nc) begin
      res = 32'hFFFFFFFF;
      foreach (got[k]) res = refCrc(res, got[k]);
      check(res == 32'hDEBB20E3, "R1 residue", res, 32'hDEBB20E3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    totalChecks++;
    failChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0; inLast = 1'b0; inNoCrc = 1'b0;
    inData = '0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1.5;
    check(!outValid, "R9 reset outValid", outValid, 0);
    check(inReady == outReady, "R9 reset inReady", inReady, outReady);
    // directed corner cases
    runFrame(1,    0, 0, 0);   // R3 minimal frame
    runFrame(59,   0, 0, 20);  // R3 one short
    runFrame(60,   0, 0, 20);  // R4 exact minimum
    runFrame(61,   0, 0, 20);  // R4
    runFrame(5,    1, 0, 20);  // R5 short no-CRC
    runFrame(70,   1, 1, 20);  // R5 later sideband ignored
    runFrame(10,   0, 1, 20);  // R5 later sideband ignored, CRC mode
    runFrame(2047, 0, 0, 30);  // R8 largest frame
    runFrame(2047, 1, 0, 10);  // R8 largest no-CRC
    runFrame(3,    0, 0, 70);  // R7 heavy backpressure
    for (int f = 0; f < 40; f++)
      runFrame(1 + int'($urandom % 150), (($urandom % 4) == 0), 1'($urandom), int'($urandom % 50));
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

endmodule